// File: doc/BRIEF.md
# MDIO Management Frame Master

This block issues register read and write frames to an Ethernet PHY over a two-wire management bus. It drives a management clock (MDC), and the MDIO data line through separate output and drive-enable signals plus a sampled input. A host starts a frame with a one-cycle start pulse. Along with the pulse it gives a read/write select, a 5-bit register number and, for writes, a 16-bit data word. The PHY address is fixed by a parameter.

Each frame has the following parts, in this order:
- a 32-bit all-ones preamble;
- a start-plus-opcode nibble;
- the PHY address;
- the register address;
- a turnaround field;
- sixteen data bits;
- one idle MDC clock with the line driven again.

When the frame is finished, the block raises a one-cycle done pulse. After a read, the 16-bit result waits on the read-data output until the next read. MDC is the system clock divided down, with each half-period lasting `DIV` system clocks.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 MDIO bit slots driven to 1 with the drive enable high.
- R2: The next four slots carry the start/opcode field MSB first: 0110 for a read (`rd_nwr`=1) and 0101 for a write (`rd_nwr`=0).
- R3: The next ten slots carry the 5-bit PHY address parameter (default 7) and then the 5-bit `reg_addr`, each MSB first.
- R4: On a write, slots 46 and 47 carry 1 then 0, and slots 48 to 63 carry `wdata` MSB first, all with the drive enable high.
- R5: On a read, `mdio_oe` is low for slot 46 (turnaround) and slots 47 to 62 (data), and is high in every other slot. `rdata` collects `mdio_i` MSB first, sampled at the system clock edge at which MDC falls at the end of each data slot. `rdata` changes only on reads.
- R6: Each bit slot is `DIV` system clocks with MDC low followed by `DIV` clocks with MDC high. `mdio_o` and `mdio_oe` change only at slot boundaries, while MDC is low.
- R7: After the data phase comes one idle slot (slot 63 for a read, slot 64 for a write) with `mdio_oe`=1 and `mdio_o`=1. `done` is high for exactly one cycle, the cycle after that slot ends.
- R8: `busy` is high from the cycle after an accepted start through the end of the idle slot, and is low while `done` is high. A start is accepted only when both `busy` and `done` are low. Otherwise it is ignored.
- R9: Between frames, MDC is low, `mdio_oe` is 1 and `mdio_o` is 1.
- R10: Synchronous active-high reset returns the block to idle, with `busy`=0, `done`=0, MDC low, the line driven high and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (sampled when idle) |
| rd_nwr | input | 1 | 1 = read frame, 0 = write frame |
| reg_addr | input | 5 | PHY register number |
| wdata | input | 16 | Data for a write frame |
| rdata | output | 16 | Data returned by the last read |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The assertions check several properties on every cycle:
- the single-cycle done pulse, and that done and busy are never high together;
- that an idle start is accepted;
- that MDC rests low and the line is driven high between frames;
- that MDIO and its enable hold still while MDC is high.

The exact bit content of each frame is shown only by the bench scenarios, which compare against a behavioural model on every clock. These scenarios cover field order and polarity, the one-slot turnaround and the slot where the drive enable returns, the sampling edge and bit order of read data, and starts ignored mid-frame or during the done cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 64;
    localparam int SLOT_W     = 7;

    localparam logic [3:0] OP_READ  = 4'b0110;
    localparam logic [3:0] OP_WRITE = 4'b0101;
    localparam logic [1:0] TA_WRITE = 2'b10;

    localparam logic [SLOT_W-1:0] TA_SLOT       = SLOT_W'(PRE_BITS + 4 + 5 + 5);
    localparam logic [SLOT_W-1:0] RD_DATA_FIRST = SLOT_W'(PRE_BITS + 4 + 5 + 5 + 1);
    localparam logic [SLOT_W-1:0] RD_DATA_LAST  = SLOT_W'(PRE_BITS + 4 + 5 + 5 + 16);
    localparam logic [SLOT_W-1:0] RD_IDLE_SLOT  = SLOT_W'(PRE_BITS + 4 + 5 + 5 + 17);
    localparam logic [SLOT_W-1:0] WR_IDLE_SLOT  = SLOT_W'(PRE_BITS + 4 + 5 + 5 + 18);

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RUN,
        SEQ_DONE
    } seq_state_t;

    typedef struct packed {
        logic        is_read;
        logic [4:0]  reg_addr;
        logic [15:0] wdata;
    } mgmt_req_t;

    function automatic logic [FRAME_BITS-1:0] frame_word(logic [4:0] phy, mgmt_req_t r);
        return {{PRE_BITS{1'b1}}, (r.is_read ? OP_READ : OP_WRITE), phy, r.reg_addr,
                TA_WRITE, r.wdata};
    endfunction

    function automatic logic [SLOT_W-1:0] idle_slot(logic is_read);
        return is_read ? RD_IDLE_SLOT : WR_IDLE_SLOT;
    endfunction

    function automatic logic line_released(logic is_read, logic [SLOT_W-1:0] s);
        return is_read && (s >= TA_SLOT) && (s <= RD_DATA_LAST);
    endfunction

    function automatic logic read_capture(logic is_read, logic [SLOT_W-1:0] s);
        return is_read && (s >= RD_DATA_FIRST) && (s <= RD_DATA_LAST);
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic slot_end
);
    localparam int SLOT_CYC = 2 * DIV;
    localparam int CW       = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [CW-1:0] HALF = CW'(DIV);
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign mdc      = run && (cnt >= HALF);
    assign slot_end = run && (cnt == LAST);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rd_in,
    input  logic              slot_end,
    output logic              load,
    output logic              busy,
    output logic              done,
    output logic              is_read,
    output logic [SLOT_W-1:0] slot
);
    seq_state_t state;

    assign load = (state == SEQ_IDLE) && start;
    assign busy = (state == SEQ_RUN);
    assign done = (state == SEQ_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            slot    <= '0;
            is_read <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state   <= SEQ_RUN;
                        slot    <= '0;
                        is_read <= rd_in;
                    end
                end
                SEQ_RUN: begin
                    if (slot_end) begin
                        if (slot == idle_slot(is_read)) begin
                            state <= SEQ_DONE;
                        end else begin
                            slot <= slot + SLOT_W'(1);
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'h07
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  mgmt_req_t   req,
    input  logic        slot_end,
    input  logic        capture,
    input  logic        mdio_i,
    output logic        tx_bit,
    output logic [15:0] rdata
);
    logic [FRAME_BITS-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
        end else if (load) begin
            shreg <= frame_word(PHY_ADDR, req);
        end else if (slot_end) begin
            shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (slot_end && capture) begin
            rdata <= {rdata[14:0], mdio_i};
        end
    end

    assign tx_bit = shreg[FRAME_BITS-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int         DIV      = 4,
    parameter logic [4:0] PHY_ADDR = 5'h07
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        rd_nwr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        busy,
    output logic        done,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              load;
    logic              slot_end;
    logic              is_read;
    logic              tx_bit;
    logic [SLOT_W-1:0] slot;
    mgmt_req_t         req;

    assign req = '{is_read: rd_nwr, reg_addr: reg_addr, wdata: wdata};

    mdio_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rd_in   (rd_nwr),
        .slot_end(slot_end),
        .load    (load),
        .busy    (busy),
        .done    (done),
        .is_read (is_read),
        .slot    (slot)
    );

    mdio_clkgen #(.DIV(DIV)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .mdc     (mdc),
        .slot_end(slot_end)
    );

    mdio_shifter #(.PHY_ADDR(PHY_ADDR)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .req     (req),
        .slot_end(slot_end),
        .capture (read_capture(is_read, slot)),
        .mdio_i  (mdio_i),
        .tx_bit  (tx_bit),
        .rdata   (rdata)
    );

    assign mdio_o  = (!busy || (slot == idle_slot(is_read))) ? 1'b1 : tx_bit;
    assign mdio_oe = !(busy && line_released(is_read, slot));
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                            // R7
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);                                            // R8
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && start) |=> busy);                        // R8
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));                               // R8
    AST_MDC_REST: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);                                            // R9
    AST_LINE_REST: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mdio_oe && mdio_o));                             // R9
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && mdc) |-> $stable(mdio_o));                         // R6
    AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && mdc) |-> $stable(mdio_oe));                        // R5
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .mdc    (mdc),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int DIV = 4;
    localparam int SL  = 2 * DIV;
    localparam logic [4:0] PHY = 5'h07;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic        mdio_i;
    logic        phy_bit = 1'b1;
    logic [15:0] phy_word = '0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_bit;

    mdio_master #(.DIV(DIV), .PHY_ADDR(PHY)) uut (
        .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr), .reg_addr(reg_addr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .done(done), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: per-slot bit list, 2 = line released
    int          m_bits[$];
    bit          m_busy, m_done, m_rd;
    int          m_t;
    logic [15:0] m_rdata;

    function automatic void build(bit rd, logic [4:0] ra, logic [15:0] wd);
        logic [3:0] op;
        m_bits.delete();
        op = rd ? 4'b0110 : 4'b0101;
        for (int i = 0; i < 32; i++) m_bits.push_back(1);
        for (int i = 3; i >= 0; i--) m_bits.push_back(int'(op[i]));
        for (int i = 4; i >= 0; i--) m_bits.push_back(int'(PHY[i]));
        for (int i = 4; i >= 0; i--) m_bits.push_back(int'(ra[i]));
        if (rd) begin
            for (int i = 0; i < 17; i++) m_bits.push_back(2);
        end else begin
            m_bits.push_back(1);
            m_bits.push_back(0);
            for (int i = 15; i >= 0; i--) m_bits.push_back(int'(wd[i]));
        end
        m_bits.push_back(1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy  <= 1'b0;
            m_done  <= 1'b0;
            m_t     <= 0;
            m_rdata <= '0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy && !m_done && start) begin
                build(rd_nwr, reg_addr, wdata);
                m_rd   <= rd_nwr;
                m_busy <= 1'b1;
                m_t    <= 0;
            end else if (m_busy) begin
                if (m_rd && (m_t % SL) == SL - 1 && (m_t / SL) >= 47 && (m_t / SL) <= 62)
                    m_rdata <= {m_rdata[14:0], mdio_i};
                if (m_t == m_bits.size() * SL - 1) begin
                    m_busy <= 1'b0;
                    m_done <= 1'b1;
                end else begin
                    m_t <= m_t + 1;
                end
            end
        end
    end

    function automatic string slot_tag(int s);
        if (s < 32) return "R1";
        if (s < 36) return "R2";
        if (s < 46) return "R3";
        if (s == m_bits.size() - 1) return "R7";
        if (m_rd) return "R5";
        return "R4";
    endfunction

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            bit exp_mdc, exp_oe, exp_o, chk_o;
            string tag;
            exp_mdc = m_busy && ((m_t % SL) >= DIV);
            exp_oe  = 1'b1;
            exp_o   = 1'b1;
            chk_o   = 1'b1;
            tag     = "R9";
            if (m_busy) begin
                int b;
                b   = m_bits[m_t / SL];
                tag = slot_tag(m_t / SL);
                if (b == 2) begin
                    exp_oe = 1'b0;
                    chk_o  = 1'b0;
                end else begin
                    exp_o = b[0];
                end
            end
            chk(busy == m_busy, "R8", "busy", int'(busy), int'(m_busy));
            chk(done == m_done, "R7", "done", int'(done), int'(m_done));
            chk(mdc == exp_mdc, "R6", "mdc", int'(mdc), int'(exp_mdc));
            chk(mdio_oe == exp_oe, (m_busy && m_rd) ? "R5" : tag, "mdio_oe",
                int'(mdio_oe), int'(exp_oe));
            if (chk_o) chk(mdio_o == exp_o, tag, "mdio_o", int'(mdio_o), int'(exp_o));
            chk(rdata == m_rdata, "R5", "rdata", int'(rdata), int'(m_rdata));
        end
    end

    // PHY responder: drives each read bit after a rising MDC
    logic pm = 1'b0;
    int   rises = 0;
    always @(negedge clk) begin
        if (!busy) begin
            rises   = 0;
            phy_bit = 1'b1;
        end else if (mdc && !pm) begin
            rises++;
            if (m_rd && rises >= 48 && rises <= 63)
                phy_bit = phy_word[15 - (rises - 48)];
        end
        pm = mdc;
    end

    task automatic wait_done();
        int n;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog actual=0 expected=1 (no done)");
        end
    endtask

    task automatic frame(input bit rd, input logic [4:0] ra, input logic [15:0] wd,
                         input logic [15:0] pw);
        @(negedge clk);
        rd_nwr   = rd;
        reg_addr = ra;
        wdata    = wd;
        phy_word = pw;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
        wait_done();
        if (rd) chk(rdata == pw, "R5", "read result", int'(rdata), int'(pw));
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL R8 global watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy == 0 && done == 0, "R10", "busy/done in reset", int'({busy, done}), 0);
        chk(mdc == 0 && mdio_oe == 1 && mdio_o == 1, "R10", "line in reset",
            int'({mdc, mdio_oe, mdio_o}), 3);
        chk(rdata == 16'h0, "R10", "rdata in reset", int'(rdata), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        frame(1'b0, 5'h00, 16'h8000, 16'h0);     // R4 write
        frame(1'b0, 5'h1F, 16'h1234, 16'h0);     // R3 all-ones address
        frame(1'b1, 5'h01, 16'h0, 16'hA5C3);     // R5 read
        frame(1'b1, 5'h00, 16'h0, 16'h0001);     // R5 LSB only
        frame(1'b0, 5'h0A, 16'hFFFF, 16'h0);     // R5 write leaves rdata
        chk(rdata == 16'h0001, "R5", "rdata held over write", int'(rdata), 1);

        // R8: starts during a frame are ignored
        @(negedge clk);
        rd_nwr = 1'b1; reg_addr = 5'h12; phy_word = 16'h3C5A; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            repeat (37) @(negedge clk);
            rd_nwr = 1'b0; reg_addr = 5'h05; wdata = 16'hDEAD; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done();
        chk(rdata == 16'h3C5A, "R8", "read unaffected by mid-frame start", int'(rdata), 16'h3C5A);
        @(negedge clk);

        // R8: start held through done is ignored in the done cycle, then accepted
        rd_nwr = 1'b0; reg_addr = 5'h03; wdata = 16'h0F0F; start = 1'b1;
        @(negedge clk);
        wait_done();
        @(negedge clk);
        chk(busy == 1'b0, "R8", "start ignored in done cycle", int'(busy), 0);
        @(negedge clk);
        chk(busy == 1'b1, "R8", "held start accepted when idle", int'(busy), 1);
        start = 1'b0;
        wait_done();
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule